// File: doc/BRIEF.md
# Placeholder Outer-Cache Controller Register Bank

This block stands in for an outer-level cache controller that is not present in the system. It answers register reads and writes in a 4 KiB window, so boot and driver software find a controller that looks plausible. It returns a fixed identity word and keeps a control bit. It also holds auxiliary settings, tag and data latency values, and a start/end address-filter pair. It reports every cache maintenance operation as already complete. No caching, tag storage or memory-side traffic takes place.

The cache-type word behaves in an unusual way. It lives in a register whose start value is a parameter. Each read of it ORs in a small field taken from the auxiliary settings, at two positions, and returns the merged value. Bits therefore collect over repeated reads.

Access uses a single-cycle register bus: select, write enable, 12-bit offset, 32-bit write data. Read data is registered and appears in the cycle after a read. A decode-error flag pulses for one cycle after any access to a location that has no meaning.

Top module: `cache_stub_regs`

## Requirements
- R1: After synchronous active-low reset, control reads 0, auxiliary settings (0x104) read 0x02020000, and tag latency (0x108), data latency (0x10C), filter start (0xC00) and filter end (0xC04) read 0.
- R2: A read of offset 0x000 returns the identity parameter (default 0x410000C8) on rdata in the cycle after the select. Read data from any read appears in that cycle.
- R3: A write to 0x100 stores only wdata bit 0. A read of 0x100 returns that bit in bit 0, with bits 31:1 zero.
- R4: Offsets 0x104, 0x108, 0x10C, 0xC00 and 0xC04 each store all 32 bits of a write and return them on read.
- R5: A read of 0x004 forms f = {aux[19:17], 1'b0, aux[16]}. It ORs f<<18 and f<<6 into the stored cache-type register, keeps the result, and returns it. The start value is the CTYPE_INIT parameter (default 0x1C100100).
- R6: Any offset from 0x730 through 0x7FF reads as 0 and drops writes, without a decode error.
- R7: Offsets 0xF40, 0xF60 and 0xF80 read as 0 and drop writes, without a decode error.
- R8: Reads and writes to any other offset, and writes to 0x000 or 0x004, return 0 or are dropped. decErr is high for exactly the one cycle after such an access and low after every valid access.
- R9: rdata changes only in the cycle after a read. After write cycles and idle cycles it keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Access select for this cycle |
| wrEn | input | 1 | 1 = write, 0 = read (when sel is high) |
| offset | input | 12 | Byte offset inside the 4 KiB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| decErr | output | 1 | One-cycle pulse after an access to a meaningless location |

## Verification
The bench builds the block with CTYPE_INIT set to zero and keeps the default identity word. Starting from an empty cache-type register makes the OR accumulation visible: the first read after reset already differs from the start value, and later auxiliary writes add new bits that the bench sees appear without earlier bits being lost. With the default start value, the reset auxiliary field would only repeat bits that are already set.

// File: rtl/cstub_pkg.sv
package cstub_pkg;

  localparam int OFF_W  = 12;
  localparam int DATA_W = 32;

  localparam logic [OFF_W-1:0] OFF_IDENT  = 12'h000;
  localparam logic [OFF_W-1:0] OFF_CTYPE  = 12'h004;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 12'h100;
  localparam logic [OFF_W-1:0] OFF_AUX    = 12'h104;
  localparam logic [OFF_W-1:0] OFF_TAGLAT = 12'h108;
  localparam logic [OFF_W-1:0] OFF_DATLAT = 12'h10C;
  localparam logic [OFF_W-1:0] OFF_FLTLO  = 12'hC00;
  localparam logic [OFF_W-1:0] OFF_FLTHI  = 12'hC04;
  localparam logic [OFF_W-1:0] OFF_IDLE0  = 12'hF40;
  localparam logic [OFF_W-1:0] OFF_IDLE1  = 12'hF60;
  localparam logic [OFF_W-1:0] OFF_IDLE2  = 12'hF80;
  localparam logic [OFF_W-1:0] MAINT_LO   = 12'h730;
  localparam logic [OFF_W-1:0] MAINT_HI   = 12'h800;

  // Full-width stored registers, index order used by the datapath.
  localparam int NWIDE   = 5;
  localparam int W_AUX   = 0;
  localparam int W_TAG   = 1;
  localparam int W_DAT   = 2;
  localparam int W_FLTLO = 3;
  localparam int W_FLTHI = 4;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_IDENT,
    SRC_CTYPE,
    SRC_CTRL,
    SRC_WIDE
  } rdSrc_e;

  typedef struct packed {
    logic             rdEn;
    rdSrc_e           rdSrc;
    logic [2:0]       wideIdx;
    logic             wrCtrl;
    logic [NWIDE-1:0] wrWide;
    logic             badAccess;
  } strobes_t;

endpackage

// File: rtl/cstub_ctrl.sv
module cstub_ctrl
  import cstub_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel,
  input  logic             wrEn,
  input  logic [OFF_W-1:0] offset,
  output strobes_t         stb,
  output logic             decErr
);

  logic inMaint;
  assign inMaint = (offset >= MAINT_LO) && (offset < MAINT_HI);

  always_comb begin
    stb         = '0;
    stb.rdSrc   = SRC_ZERO;
    stb.rdEn    = sel && !wrEn;
    if (sel && !inMaint) begin
      case (offset)
        OFF_IDENT: begin
          if (wrEn) stb.badAccess = 1'b1;
          else      stb.rdSrc     = SRC_IDENT;
        end
        OFF_CTYPE: begin
          if (wrEn) stb.badAccess = 1'b1;
          else      stb.rdSrc     = SRC_CTYPE;
        end
        OFF_CTRL: begin
          if (wrEn) stb.wrCtrl = 1'b1;
          else      stb.rdSrc  = SRC_CTRL;
        end
        OFF_AUX: begin
          stb.wideIdx = 3'(W_AUX);
          if (wrEn) stb.wrWide[W_AUX] = 1'b1;
          else      stb.rdSrc         = SRC_WIDE;
        end
        OFF_TAGLAT: begin
          stb.wideIdx = 3'(W_TAG);
          if (wrEn) stb.wrWide[W_TAG] = 1'b1;
          else      stb.rdSrc         = SRC_WIDE;
        end
        OFF_DATLAT: begin
          stb.wideIdx = 3'(W_DAT);
          if (wrEn) stb.wrWide[W_DAT] = 1'b1;
          else      stb.rdSrc         = SRC_WIDE;
        end
        OFF_FLTLO: begin
          stb.wideIdx = 3'(W_FLTLO);
          if (wrEn) stb.wrWide[W_FLTLO] = 1'b1;
          else      stb.rdSrc           = SRC_WIDE;
        end
        OFF_FLTHI: begin
          stb.wideIdx = 3'(W_FLTHI);
          if (wrEn) stb.wrWide[W_FLTHI] = 1'b1;
          else      stb.rdSrc           = SRC_WIDE;
        end
        OFF_IDLE0, OFF_IDLE1, OFF_IDLE2: begin
          stb.rdSrc = SRC_ZERO;
        end
        default: stb.badAccess = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) decErr <= 1'b0;
    else       decErr <= stb.badAccess;
  end

endmodule

// File: rtl/cstub_dpath.sv
module cstub_dpath
  import cstub_pkg::*;
#(
  parameter logic [31:0] IDENT_WORD = 32'h4100_00C8,
  parameter logic [31:0] CTYPE_INIT = 32'h1C10_0100,
  parameter logic [31:0] AUX_INIT   = 32'h0202_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int FIELD_W  = 5;
  localparam int POS_HIGH = 18;
  localparam int POS_LOW  = 6;

  logic                ctrlBit;
  logic [DATA_W-1:0]   wideReg [NWIDE];
  logic [DATA_W-1:0]   ctypeReg;
  logic [FIELD_W-1:0]  auxField;
  logic [DATA_W-1:0]   ctypeMerged;
  logic [DATA_W-1:0]   rdNext;

  // Field drawn from the auxiliary settings: ways/size bits above, associativity bit at 0.
  assign auxField    = {wideReg[W_AUX][19:17], 1'b0, wideReg[W_AUX][16]};
  assign ctypeMerged = ctypeReg
                     | ({{(DATA_W-FIELD_W){1'b0}}, auxField} << POS_HIGH)
                     | ({{(DATA_W-FIELD_W){1'b0}}, auxField} << POS_LOW);

  always_ff @(posedge clk) begin
    if (!rstN) ctrlBit <= 1'b0;
    else if (stb.wrCtrl) ctrlBit <= wdata[0];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NWIDE; i++) begin
      if (!rstN)              wideReg[i] <= (i == W_AUX) ? AUX_INIT : '0;
      else if (stb.wrWide[i]) wideReg[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctypeReg <= CTYPE_INIT;
    else if (stb.rdEn && stb.rdSrc == SRC_CTYPE) ctypeReg <= ctypeMerged;
  end

  always_comb begin
    case (stb.rdSrc)
      SRC_IDENT: rdNext = IDENT_WORD;
      SRC_CTYPE: rdNext = ctypeMerged;
      SRC_CTRL:  rdNext = {{(DATA_W-1){1'b0}}, ctrlBit};
      SRC_WIDE:  rdNext = (int'(stb.wideIdx) < NWIDE) ? wideReg[stb.wideIdx] : '0;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdata <= '0;
    else if (stb.rdEn) rdata <= rdNext;
  end

endmodule

// File: rtl/cache_stub_regs.sv
module cache_stub_regs
  import cstub_pkg::*;
#(
  parameter logic [31:0] IDENT_WORD = 32'h4100_00C8,
  parameter logic [31:0] CTYPE_INIT = 32'h1C10_0100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sel,
  input  logic        wrEn,
  input  logic [11:0] offset,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        decErr
);

  strobes_t stb;

  cstub_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sel    (sel),
    .wrEn   (wrEn),
    .offset (offset),
    .stb    (stb),
    .decErr (decErr)
  );

  cstub_dpath #(
    .IDENT_WORD (IDENT_WORD),
    .CTYPE_INIT (CTYPE_INIT),
    .AUX_INIT   (32'h0202_0000)
  ) u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wdata (wdata),
    .rdata (rdata)
  );

endmodule

// File: rtl/cache_stub_regs_chk.sv
module cache_stub_regs_chk #(
  parameter logic [31:0] IDENT_WORD = 32'h4100_00C8
) (
  input logic        clk,
  input logic        rstN,
  input logic        sel,
  input logic        wrEn,
  input logic [11:0] offset,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        decErr
);

  logic [1:0]  armed;
  logic        isRead;
  logic        ctSeen;
  logic [31:0] ctPrev;

  assign isRead = sel && !wrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= '0;
      ctSeen <= 1'b0;
      ctPrev <= '0;
    end else begin
      if (armed != 2'd3) armed <= armed + 2'd1;
      if (armed != 2'd0 && $past(isRead) && $past(offset) == 12'h004) begin
        ctSeen <= 1'b1;
        ctPrev <= rdata;
      end
    end
  end

  // R2: identity word one cycle after a read of offset 0
  a_r2_ident: assert property (@(posedge clk) disable iff (!rstN || armed == 2'd0)
    $past(isRead) && $past(offset) == 12'h000 |-> rdata == IDENT_WORD);

  // R3: control readback has only bit 0
  a_r3_ctrl_bit0: assert property (@(posedge clk) disable iff (!rstN || armed == 2'd0)
    $past(isRead) && $past(offset) == 12'h100 |-> rdata[31:1] == 31'd0);

  // R4: write then immediate read of auxiliary settings returns the written word
  a_r4_aux_store: assert property (@(posedge clk) disable iff (!rstN || armed != 2'd3)
    $past(sel, 2) && $past(wrEn, 2) && $past(offset, 2) == 12'h104 &&
    $past(isRead) && $past(offset) == 12'h104 |-> rdata == $past(wdata, 2));

  // R5: cache-type readback never loses a bit seen earlier
  a_r5_ctype_grow: assert property (@(posedge clk) disable iff (!rstN || armed == 2'd0)
    ctSeen && $past(isRead) && $past(offset) == 12'h004 |-> (rdata & ctPrev) == ctPrev);

  // R6: maintenance range reads zero with no error
  a_r6_maint_zero: assert property (@(posedge clk) disable iff (!rstN || armed == 2'd0)
    $past(isRead) && $past(offset) >= 12'h730 && $past(offset) < 12'h800
    |-> rdata == 32'd0 && !decErr);

  // R8: an error pulse always follows an access
  a_r8_err_after_sel: assert property (@(posedge clk) disable iff (!rstN || armed == 2'd0)
    decErr |-> $past(sel));

  // R9: read data holds unless a read was made
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rstN || armed == 2'd0)
    !$past(isRead) |-> $stable(rdata));

endmodule

bind cache_stub_regs cache_stub_regs_chk #(.IDENT_WORD(IDENT_WORD)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .sel    (sel),
  .wrEn   (wrEn),
  .offset (offset),
  .wdata  (wdata),
  .rdata  (rdata),
  .decErr (decErr)
);

// File: tb/cache_stub_regs_bench.sv
module cache_stub_regs_bench;

  localparam logic [31:0] IDENT = 32'h4100_00C8;
  localparam logic [31:0] CT0   = 32'h0000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] offset = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        decErr;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  // bench model state
  logic        mCtrl;
  logic [31:0] mAux, mTag, mDat, mFlo, mFhi, mCt, mLastRd;

  cache_stub_regs #(.IDENT_WORD(IDENT), .CTYPE_INIT(CT0)) u_cache_stub_regs (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .offset(offset),
    .wdata(wdata), .rdata(rdata), .decErr(decErr)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [11:0] off, input bit isWr);
    if (off >= 12'h730 && off < 12'h800) return "R6";
    case (off)
      12'h000: return isWr ? "R8" : "R2";
      12'h004: return isWr ? "R8" : "R5";
      12'h100: return "R3";
      12'h104, 12'h108, 12'h10C, 12'hC00, 12'hC04: return "R4";
      12'hF40, 12'hF60, 12'hF80: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic modelReset();
    mCtrl = 1'b0; mAux = 32'h0202_0000; mTag = '0; mDat = '0;
    mFlo = '0; mFhi = '0; mCt = CT0; mLastRd = '0;
  endtask

  // Apply one access to the model, produce expected read data and error flag.
  task automatic modelAccess(input bit isWr, input logic [11:0] off, input logic [31:0] d,
                             output logic [31:0] expRd, output bit expErr);
    logic [4:0] f;
    expRd = 32'd0;
    expErr = 1'b0;
    if (off >= 12'h730 && off < 12'h800) begin
      expRd = 32'd0;
    end else begin
      case (off)
        12'h000: if (isWr) expErr = 1'b1; else expRd = IDENT;
        12'h004: if (isWr) expErr = 1'b1; else begin
          f = {mAux[19:17], 1'b0, mAux[16]};
          mCt = mCt | (32'(f) << 18) | (32'(f) << 6);
          expRd = mCt;
        end
        12'h100: if (isWr) mCtrl = d[0]; else expRd = {31'd0, mCtrl};
        12'h104: if (isWr) mAux = d; else expRd = mAux;
        12'h108: if (isWr) mTag = d; else expRd = mTag;
        12'h10C: if (isWr) mDat = d; else expRd = mDat;
        12'hC00: if (isWr) mFlo = d; else expRd = mFlo;
        12'hC04: if (isWr) mFhi = d; else expRd = mFhi;
        12'hF40, 12'hF60, 12'hF80: expRd = 32'd0;
        default: expErr = 1'b1;
      endcase
    end
    if (isWr) expRd = mLastRd;   // R9: writes leave rdata alone
    else      mLastRd = expRd;
  endtask

  task automatic acc(input bit isWr, input logic [11:0] off, input logic [31:0] d);
    logic [31:0] expRd;
    bit expErr;
    string req;
    req = reqOf(off, isWr);
    modelAccess(isWr, off, d, expRd, expErr);
    @(negedge clk);
    sel = 1'b1; wrEn = isWr; offset = off; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0;
    check(isWr ? "R9" : req, rdata, expRd);
    check("R8", {31'd0, decErr}, {31'd0, expErr});
  endtask

  task automatic idleCheck();
    @(negedge clk);
    @(negedge clk);
    check("R8", {31'd0, decErr}, 32'd0);
    check("R9", rdata, mLastRd);
  endtask

  function automatic logic [11:0] pickOff(input int unsigned r);
    case (r % 20)
      0: return 12'h000;   1: return 12'h004;   2: return 12'h100;
      3: return 12'h104;   4: return 12'h108;   5: return 12'h10C;
      6: return 12'hC00;   7: return 12'hC04;   8: return 12'hF40;
      9: return 12'hF60;   10: return 12'hF80;  11: return 12'h730;
      12: return 12'h7FC;  13: return 12'h72C;  14: return 12'h800;
      15: return 12'h004;  16: return 12'h104;
      default: return 12'($urandom);
    endcase
  endfunction

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20240611);
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values
    acc(1'b0, 12'h100, 0);
    acc(1'b0, 12'h104, 0);
    acc(1'b0, 12'h108, 0);
    acc(1'b0, 12'h10C, 0);
    acc(1'b0, 12'hC00, 0);
    acc(1'b0, 12'hC04, 0);
    // R2: identity, write attempt is an error and changes nothing
    acc(1'b0, 12'h000, 0);
    acc(1'b1, 12'h000, 32'hDEAD_BEEF);
    acc(1'b0, 12'h000, 0);
    // R5: accumulate from zero start, then grow with new aux field
    acc(1'b0, 12'h004, 0);
    acc(1'b0, 12'h004, 0);
    acc(1'b1, 12'h004, 32'hFFFF_FFFF);
    acc(1'b1, 12'h104, 32'h000F_0000);
    acc(1'b0, 12'h004, 0);
    acc(1'b1, 12'h104, 32'h0000_0000);
    acc(1'b0, 12'h004, 0);
    // R3: control keeps bit 0 only
    acc(1'b1, 12'h100, 32'hFFFF_FFFE);
    acc(1'b0, 12'h100, 0);
    acc(1'b1, 12'h100, 32'h8000_0001);
    acc(1'b0, 12'h100, 0);
    // R4: full-width patterns
    acc(1'b1, 12'h108, 32'hA5A5_5A5A);
    acc(1'b1, 12'hC04, 32'hFFFF_FFFF);
    acc(1'b0, 12'h108, 0);
    acc(1'b0, 12'hC04, 0);
    // R6: maintenance edges, R8 just outside
    acc(1'b1, 12'h730, 32'h1234_5678);
    acc(1'b1, 12'h7FF, 32'h1234_5678);
    acc(1'b0, 12'h730, 0);
    acc(1'b0, 12'h7FF, 0);
    acc(1'b0, 12'h72F, 0);
    acc(1'b0, 12'h800, 0);
    // R7: idle ports
    acc(1'b1, 12'hF60, 32'hFFFF_FFFF);
    acc(1'b0, 12'hF40, 0);
    acc(1'b0, 12'hF80, 0);
    // R8: unlisted write dropped, pulse lasts one cycle
    acc(1'b1, 12'h110, 32'h5555_5555);
    idleCheck();
    acc(1'b0, 12'h108, 0);
    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom;
      acc(r[31], pickOff($urandom), $urandom);
      if (r[3:0] == 4'd0) idleCheck();
    end
    // R1: reset again restores defaults
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    modelReset();
    check("R1", rdata, 32'd0);
    acc(1'b0, 12'h104, 0);
    acc(1'b0, 12'h004, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule